// File: doc/BRIEF.md
# Prescaled Event Counter

This block divides a stream of tick enables by a programmable amount and counts the resulting events. A down-counter steps toward zero on each tick. Once it has spent one whole tick at zero, the next tick loads it from a software-set reload value and, in that same tick, advances a 32-bit event counter. The effective division ratio is therefore reload + 1 ticks per event, with a reload of zero giving one event per tick.

The ticks come from a single-cycle enable produced elsewhere from a prescale clock, typically running at 20 MHz. All state lives in the main clock domain. Software sees the reload value, the down-counter and the event counter through one shared write-data bus with a separate write strobe for each register. Each register is visible on its own output. Address decoding and tick generation sit outside the block.

Top module: `evt_prescale_counter`

## Requirements
- R1: After reset the reload value, the down-counter and the event counter all read zero.
- R2: On a tick, a nonzero down-counter that is not being written drops by exactly one, and the event counter does not change.
- R3: On a tick that finds the down-counter at zero, the down-counter takes the reload value and the event counter rises by one, both in that tick.
- R4: With a reload of zero, the down-counter stays at zero and the event counter rises by one on every tick.
- R5: In a cycle with no tick and no write strobe, all three registers keep their values.
- R6: Writing the reload value leaves the down-counter unchanged. The new value is used the next time the down-counter reloads.
- R7: Software can load the down-counter and the event counter directly, and later ticks count on from the loaded values.
- R8: The event counter wraps from 0xFFFFFFFF to 0 when it increments.
- R9: When a write strobe and a tick come in the same cycle, the written register takes the write data. The other registers still follow the tick.
- R10: With the down-counter at 7 and a reload of 5, the event counter first rises on tick 8 and then on ticks 14 and 20. The down-counter reads 5 right after tick 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per prescale clock period |
| wdata | input | 32 | Write data shared by all strobes |
| wr_reload | input | 1 | Write strobe for the reload value |
| wr_down | input | 1 | Write strobe for the down-counter |
| wr_count | input | 1 | Write strobe for the event counter |
| reload_q | output | 32 | Current reload value |
| down_q | output | 32 | Current down-counter value |
| count_q | output | 32 | Current event counter value |

## Verification
On every cycle, the assertions check the single-tick rules: the decrement of a nonzero down-counter, the reload and increment from zero, the sticking at zero under a zero reload, holding when idle, and the precedence of writes. Other behaviours appear only over several ticks, so the bench's directed scenarios must show them. These are the period of reload + 1 ticks starting from an arbitrary down-counter value, a new reload value taking effect only at the following reload, counting on from values loaded by software, and the wrap of the event counter.

// File: rtl/evt_prescale_counter.sv
module evt_prescale_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic [W-1:0] wdata,
  input  logic         wr_reload,
  input  logic         wr_down,
  input  logic         wr_count,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] down_q,
  output logic [W-1:0] count_q
);

  logic at_zero;
  logic fire;

  assign at_zero = (down_q == '0);
  assign fire    = tick_en && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (wr_reload) reload_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       down_q <= '0;
    else if (wr_down) down_q <= wdata;
    else if (fire)    down_q <= reload_q;
    else if (tick_en) down_q <= down_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (wr_count) count_q <= wdata;
    else if (fire)     count_q <= count_q + 1'b1;
  end

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_down && !wr_count && down_q != '0)
      |=> (down_q == $past(down_q) - 1'b1) && $stable(count_q));

  a_r3_reload_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_down && !wr_count && down_q == '0)
      |=> (down_q == $past(reload_q)) && (count_q == $past(count_q) + 1'b1));

  a_r4_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_down && down_q == '0 && reload_q == '0)
      |=> down_q == '0);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_reload && !wr_down && !wr_count)
      |=> $stable(reload_q) && $stable(down_q) && $stable(count_q));

  a_r6_reload_no_touch: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_reload && !wr_down && !tick_en) |=> $stable(down_q));

  a_r9_count_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> count_q == $past(wdata));

  a_r9_down_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_down |=> down_q == $past(wdata));

endmodule

// File: tb/test_evt_prescale_counter.sv
module test_evt_prescale_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [31:0] wdata = '0;
  logic        wr_reload = 1'b0, wr_down = 1'b0, wr_count = 1'b0;
  logic [31:0] reload_q, down_q, count_q;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_prescale_counter i_evt_prescale_counter (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdata(wdata),
    .wr_reload(wr_reload), .wr_down(wr_down), .wr_count(wr_count),
    .reload_q(reload_q), .down_q(down_q), .count_q(count_q));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(bit tk, bit wr, bit wd, bit wc, logic [31:0] d);
    tick_en = tk; wr_reload = wr; wr_down = wd; wr_count = wc; wdata = d;
    @(negedge clk);
    tick_en = 0; wr_reload = 0; wr_down = 0; wr_count = 0; wdata = '0;
  endtask

  task automatic load(logic [31:0] rl, logic [31:0] dn, logic [31:0] ct);
    cyc(0, 1, 0, 0, rl);
    cyc(0, 0, 1, 0, dn);
    cyc(0, 0, 0, 1, ct);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, '0);
  endtask

  task automatic t_reset;
    chk("R1 reload", reload_q, 0);
    chk("R1 down", down_q, 0);
    chk("R1 count", count_q, 0);
  endtask

  task automatic t_decrement;
    load(32'd9, 32'd3, 32'd40);
    chk("R7 down loaded", down_q, 3);
    ticks(1);
    chk("R2 down", down_q, 2);
    chk("R2 count", count_q, 40);
    cyc(0, 0, 0, 0, 32'hDEAD_BEEF);
    chk("R5 down", down_q, 2);
    chk("R5 count", count_q, 40);
    chk("R5 reload", reload_q, 9);
    ticks(3);
    chk("R7 count resumes", count_q, 41);
    chk("R7 down reload", down_q, 9);
  endtask

  task automatic t_example;
    load(32'd5, 32'd7, 32'd0);
    ticks(7);
    chk("R10 count tick7", count_q, 0);
    chk("R10 down tick7", down_q, 0);
    ticks(1);
    chk("R10 count tick8", count_q, 1);
    chk("R3 down tick8", down_q, 5);
    ticks(5);
    chk("R10 count tick13", count_q, 1);
    ticks(1);
    chk("R10 count tick14", count_q, 2);
    ticks(6);
    chk("R10 count tick20", count_q, 3);
  endtask

  task automatic t_zero_reload;
    load(32'd0, 32'd0, 32'd10);
    ticks(4);
    chk("R4 count", count_q, 14);
    chk("R4 down", down_q, 0);
  endtask

  task automatic t_reload_write;
    load(32'd5, 32'd4, 32'd0);
    cyc(0, 1, 0, 0, 32'd9);
    chk("R6 down kept", down_q, 4);
    chk("R6 reload", reload_q, 9);
    ticks(4);
    chk("R6 down zero", down_q, 0);
    ticks(1);
    chk("R6 new reload used", down_q, 9);
    chk("R3 count", count_q, 1);
  endtask

  task automatic t_wrap;
    load(32'd2, 32'd0, 32'hFFFF_FFFF);
    ticks(1);
    chk("R8 wrap", count_q, 0);
    chk("R3 down", down_q, 2);
  endtask

  task automatic t_priority;
    load(32'd3, 32'd0, 32'd5);
    cyc(1, 0, 0, 1, 32'd100);
    chk("R9 count written", count_q, 100);
    chk("R9 down follows tick", down_q, 3);
    cyc(1, 0, 1, 0, 32'd50);
    chk("R9 down written", down_q, 50);
    chk("R9 count held", count_q, 100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decrement();
    t_example();
    t_zero_reload();
    t_reload_write();
    t_wrap();
    t_priority();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule